// File: doc/BRIEF.md
# Debug Data Transfer Access Trap Router

This block sits beside the system-register decode stage of a processor core. It looks at one decoded system-register access and decides whether that access, if it names the debug data-transfer register, may finish or must be diverted as a trap. If it must trap, the block also picks the exception level that takes the trap and supplies the syndrome class. It is purely combinational. The verdict therefore follows the access fields and the configuration controls within the same cycle. Raising the trap itself is left to the core's exception logic.

The decision runs a short priority chain that depends on the level the access comes from. Level 0 has three checks in a fixed order. The first is the user-level comms trap, which the host-route control can send on to level 2 instead of level 1. Level 1 has two checks. Level 2 has only the level-3 debug check. Level 3 never traps. A level that runs in 32-bit state switches off every check that depends on that level's controls. Reads and writes follow the same rules.

Top module: `dtr_trap_router`

## Requirements
- R1: The access is treated as a hit only when op0=2'b10, op1=3'b011, crn=4'b0000, crm=4'b0100 and op2=3'b000. For any other encoding, both `allow` and `trap` are 0.
- R2: For a hit, exactly one of `allow` and `trap` is 1.
- R3: `trap_class` is 6'h18 whenever `trap` is 1 and 0 otherwise. `trap_el` is 0 whenever `trap` is 0. Levels are binary-coded on `cur_el` and `trap_el` (0 to 3).
- R4: At level 0 the first check is this: level 1 is not narrow and `user_comms_trap` is set. The access then traps to level 2 if `el2_enabled` is set, level 2 is not narrow and `host_route` is set. Otherwise it traps to level 1.
- R5: At level 0, if R4 does not apply, the access traps to level 2 when `el2_enabled` is set, level 2 is not narrow, and any of `host_route`, `el2_dbg_route` or `el2_dbg_access` is set.
- R6: At levels 0 and 1, if no earlier check applies, the access traps to level 3 when `el3_present` is set, level 3 is not narrow and `el3_dbg_access` is set.
- R7: At level 1 the first check traps to level 2 when `el2_enabled` is set, level 2 is not narrow and either `el2_dbg_route` or `el2_dbg_access` is set. `host_route` has no effect at level 1.
- R8: At level 2 only the R6 level-3 condition can trap, to level 3. At level 3 a hit is always allowed.
- R9: `is_write` has no effect on any output.
- R10: A narrow (32-bit) level disables its checks. `el1_narrow` disables the R4 check. `el2_narrow` disables the level-2 routing of R4, R5 and R7. `el3_narrow` disables the R6 check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_el | input | 2 | Exception level issuing the access |
| op0 | input | 2 | Access encoding field op0 |
| op1 | input | 3 | Access encoding field op1 |
| crn | input | 4 | Access encoding field CRn |
| crm | input | 4 | Access encoding field CRm |
| op2 | input | 3 | Access encoding field op2 |
| is_write | input | 1 | 1 for a write, 0 for a read |
| el2_enabled | input | 1 | Level 2 is enabled in the current state |
| el3_present | input | 1 | Level 3 is implemented |
| el1_narrow | input | 1 | Level 1 runs in 32-bit state |
| el2_narrow | input | 1 | Level 2 runs in 32-bit state |
| el3_narrow | input | 1 | Level 3 runs in 32-bit state |
| user_comms_trap | input | 1 | Trap level-0 debug comms accesses |
| host_route | input | 1 | Route level-0 traps to level 2 (host mode) |
| el2_dbg_route | input | 1 | Level-2 control routing debug exceptions and accesses |
| el2_dbg_access | input | 1 | Level-2 trap on debug register access |
| el3_dbg_access | input | 1 | Level-3 trap on debug register access |
| allow | output | 1 | Hit that completes normally |
| trap | output | 1 | Hit that must trap |
| trap_el | output | 2 | Level that takes the trap |
| trap_class | output | 6 | Syndrome class of the trap |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench drives a new access on the falling edge and compares all four outputs one nanosecond after the next rising edge. By then the inputs have been stable for half a period, and no edge is near. For each combination of level, controls and direction, the behavioural model's verdict is compared in that same cycle. The write half of each read/write pair is also compared against the read half applied one cycle earlier.

// File: rtl/dtr_trap_pkg.sv
package dtr_trap_pkg;

    localparam int EL_W       = 2;
    localparam int NUM_LEVELS = 1 << EL_W;
    localparam int EC_W       = 6;

    typedef enum logic [EL_W-1:0] {
        LVL_USER   = 2'd0,
        LVL_KERNEL = 2'd1,
        LVL_HYP    = 2'd2,
        LVL_MON    = 2'd3
    } level_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sreg_enc_t;

    localparam sreg_enc_t DTR_ENC = '{
        op0: 2'b10, op1: 3'b011, crn: 4'b0000, crm: 4'b0100, op2: 3'b000
    };

    localparam logic [EC_W-1:0] EC_DBG_ACCESS = 6'h18;

    typedef struct packed {
        logic el2_enabled;
        logic el3_present;
        logic el1_narrow;
        logic el2_narrow;
        logic el3_narrow;
        logic user_comms_trap;
        logic host_route;
        logic el2_dbg_route;
        logic el2_dbg_access;
        logic el3_dbg_access;
    } trap_ctrl_t;

    typedef struct packed {
        logic   trap;
        level_e target;
    } verdict_t;

    // Qualified conditions shared by every level's chain.
    typedef struct packed {
        logic el1_wide;
        logic el2_wide;
        logic el3_wide;
        logic el2_dbg_any;
        logic el3_dbg_hit;
    } gate_t;

    function automatic gate_t derive_gates(input trap_ctrl_t c);
        gate_t g;
        g.el1_wide    = !c.el1_narrow;
        g.el2_wide    = c.el2_enabled && !c.el2_narrow;
        g.el3_wide    = c.el3_present && !c.el3_narrow;
        g.el2_dbg_any = c.el2_dbg_route || c.el2_dbg_access;
        g.el3_dbg_hit = g.el3_wide && c.el3_dbg_access;
        return g;
    endfunction

    function automatic verdict_t pass_through();
        verdict_t v;
        v.trap   = 1'b0;
        v.target = LVL_USER;
        return v;
    endfunction

    function automatic verdict_t trap_to(input level_e lvl);
        verdict_t v;
        v.trap   = 1'b1;
        v.target = lvl;
        return v;
    endfunction

endpackage

// File: rtl/dtr_enc_match.sv
module dtr_enc_match
    import dtr_trap_pkg::*;
#(
    parameter sreg_enc_t MATCH = DTR_ENC
) (
    input  sreg_enc_t enc,
    output logic      hit
);
    localparam int FIELDS = 5;

    logic [FIELDS-1:0] field_eq;

    always_comb begin
        field_eq[0] = (enc.op0 == MATCH.op0);
        field_eq[1] = (enc.op1 == MATCH.op1);
        field_eq[2] = (enc.crn == MATCH.crn);
        field_eq[3] = (enc.crm == MATCH.crm);
        field_eq[4] = (enc.op2 == MATCH.op2);
    end

    assign hit = &field_eq;

endmodule

// File: rtl/dtr_level_chain.sv
module dtr_level_chain
    import dtr_trap_pkg::*;
#(
    parameter level_e LEVEL = LVL_USER
) (
    input  trap_ctrl_t ctrl,
    output verdict_t   verdict
);
    gate_t g;
    logic  unused_ctrl_bits;

    assign g                = derive_gates(ctrl);
    assign unused_ctrl_bits = ^{ctrl, g};

    if (LEVEL == LVL_USER) begin : g_user
        always_comb begin
            if (g.el1_wide && ctrl.user_comms_trap) begin
                verdict = (g.el2_wide && ctrl.host_route) ? trap_to(LVL_HYP)
                                                          : trap_to(LVL_KERNEL);
            end else if (g.el2_wide && (ctrl.host_route || g.el2_dbg_any)) begin
                verdict = trap_to(LVL_HYP);
            end else if (g.el3_dbg_hit) begin
                verdict = trap_to(LVL_MON);
            end else begin
                verdict = pass_through();
            end
        end
    end else if (LEVEL == LVL_KERNEL) begin : g_kernel
        always_comb begin
            if (g.el2_wide && g.el2_dbg_any) begin
                verdict = trap_to(LVL_HYP);
            end else if (g.el3_dbg_hit) begin
                verdict = trap_to(LVL_MON);
            end else begin
                verdict = pass_through();
            end
        end
    end else if (LEVEL == LVL_HYP) begin : g_hyp
        always_comb begin
            verdict = g.el3_dbg_hit ? trap_to(LVL_MON) : pass_through();
        end
    end else begin : g_mon
        assign verdict = pass_through();
    end

endmodule

// File: rtl/dtr_verdict_mux.sv
module dtr_verdict_mux
    import dtr_trap_pkg::*;
#(
    parameter int LEVELS = NUM_LEVELS,
    parameter logic [EC_W-1:0] TRAP_EC = EC_DBG_ACCESS
) (
    input  level_e          cur,
    input  logic            hit,
    input  verdict_t        cand [LEVELS],
    output logic            allow,
    output logic            trap,
    output logic [EL_W-1:0] trap_el,
    output logic [EC_W-1:0] trap_class
);
    verdict_t sel;

    assign sel        = cand[cur];
    assign trap       = hit && sel.trap;
    assign allow      = hit && !sel.trap;
    assign trap_el    = trap ? sel.target : '0;
    assign trap_class = trap ? TRAP_EC : '0;

    always_comb begin
        p_class_r3: assert (trap ? (trap_class == EC_DBG_ACCESS) : (trap_class == '0 && trap_el == '0));
    end

endmodule

// File: rtl/dtr_trap_router.sv
module dtr_trap_router
    import dtr_trap_pkg::*;
(
    input  logic [1:0] cur_el,
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    input  logic       is_write,
    input  logic       el2_enabled,
    input  logic       el3_present,
    input  logic       el1_narrow,
    input  logic       el2_narrow,
    input  logic       el3_narrow,
    input  logic       user_comms_trap,
    input  logic       host_route,
    input  logic       el2_dbg_route,
    input  logic       el2_dbg_access,
    input  logic       el3_dbg_access,
    output logic       allow,
    output logic       trap,
    output logic [1:0] trap_el,
    output logic [5:0] trap_class
);
    sreg_enc_t  enc;
    trap_ctrl_t ctrl;
    logic       hit;
    verdict_t   cand [NUM_LEVELS];
    logic       unused_dir;

    // Direction is deliberately not consulted: reads and writes share one rule set.
    assign unused_dir = is_write;

    assign enc = '{op0: op0, op1: op1, crn: crn, crm: crm, op2: op2};

    assign ctrl = '{
        el2_enabled:     el2_enabled,
        el3_present:     el3_present,
        el1_narrow:      el1_narrow,
        el2_narrow:      el2_narrow,
        el3_narrow:      el3_narrow,
        user_comms_trap: user_comms_trap,
        host_route:      host_route,
        el2_dbg_route:   el2_dbg_route,
        el2_dbg_access:  el2_dbg_access,
        el3_dbg_access:  el3_dbg_access
    };

    dtr_enc_match #(.MATCH(DTR_ENC)) u_match (
        .enc (enc),
        .hit (hit)
    );

    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_lvl
        dtr_level_chain #(.LEVEL(level_e'(lv))) u_chain (
            .ctrl    (ctrl),
            .verdict (cand[lv])
        );
    end

    dtr_verdict_mux #(.LEVELS(NUM_LEVELS), .TRAP_EC(EC_DBG_ACCESS)) u_mux (
        .cur        (level_e'(cur_el)),
        .hit        (hit),
        .cand       (cand),
        .allow      (allow),
        .trap       (trap),
        .trap_el    (trap_el),
        .trap_class (trap_class)
    );

    always_comb begin
        p_nohit_r1:     assert (hit || (!allow && !trap));
        p_excl_r2:      assert (!hit || (allow ^ trap));
        p_upward_r6:    assert (!trap || (trap_el > cur_el));
        p_mon_allow_r8: assert (!(hit && cur_el == 2'd3) || allow);
    end

endmodule

// File: tb/tb_dtr_trap_router.sv
`timescale 1ns/1ps
module tb_dtr_trap_router;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [1:0] cur_el;
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn, crm;
    logic [2:0] op2;
    logic       is_write;
    logic [9:0] cfg;
    logic       allow, trap;
    logic [1:0] trap_el;
    logic [5:0] trap_class;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    localparam logic [15:0] HIT_ENC = {2'b10, 3'b011, 4'b0000, 4'b0100, 3'b000};

    dtr_trap_router dut (
        .cur_el(cur_el), .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
        .is_write(is_write),
        .el2_enabled(cfg[0]), .el3_present(cfg[1]), .el1_narrow(cfg[2]),
        .el2_narrow(cfg[3]), .el3_narrow(cfg[4]), .user_comms_trap(cfg[5]),
        .host_route(cfg[6]), .el2_dbg_route(cfg[7]), .el2_dbg_access(cfg[8]),
        .el3_dbg_access(cfg[9]),
        .allow(allow), .trap(trap), .trap_el(trap_el), .trap_class(trap_class)
    );

    // Behavioural model: returns {allow, trap, level}.
    function automatic logic [3:0] model(input logic [1:0] el, input logic [9:0] c,
                                         input logic [15:0] e, output string tag);
        bit w1, w2, w3, dbg2, mon;
        w1 = !c[2];
        w2 = c[0] && !c[3];
        w3 = c[1] && !c[4];
        dbg2 = c[7] || c[8];
        mon = w3 && c[9];
        if (e != HIT_ENC) begin tag = "R1"; return 4'b0000; end
        if (el == 0) begin
            if (w1 && c[5]) begin tag = "R4"; return (w2 && c[6]) ? 4'b0110 : 4'b0101; end
            if (w2 && (c[6] || dbg2)) begin tag = "R5"; return 4'b0110; end
            if (mon) begin tag = "R6"; return 4'b0111; end
            tag = "R10"; return 4'b1000;
        end else if (el == 1) begin
            if (w2 && dbg2) begin tag = "R7"; return 4'b0110; end
            if (mon) begin tag = "R6"; return 4'b0111; end
            tag = "R7"; return 4'b1000;
        end else if (el == 2) begin
            tag = "R8";
            return mon ? 4'b0111 : 4'b1000;
        end
        tag = "R8";
        return 4'b1000;
    endfunction

    task automatic check_now(input string tag);
        logic [3:0] exp;
        string      mtag;
        exp = model(cur_el, cfg, {op0, op1, crn, crm, op2}, mtag);
        checks++;
        if ({allow, trap, trap_el} !== exp) begin
            fails++;
            $display("FAIL %s/%s el=%0d cfg=%b: got allow=%0b trap=%0b el=%0d, expected allow=%0b trap=%0b el=%0d",
                     tag, mtag, cur_el, cfg, allow, trap, trap_el, exp[3], exp[2], exp[1:0]);
        end
        checks++;
        if (trap_class !== (exp[2] ? 6'h18 : 6'h00)) begin
            fails++;
            $display("FAIL R3 class: got %h expected %h", trap_class, exp[2] ? 6'h18 : 6'h00);
        end
    endtask

    task automatic apply(input logic [1:0] el, input logic [9:0] c,
                         input logic [15:0] e, input logic wr);
        @(negedge clk);
        cur_el = el; cfg = c; is_write = wr;
        {op0, op1, crn, crm, op2} = e;
        @(posedge clk);
        #1;
    endtask

    task automatic run(input logic [1:0] el, input logic [9:0] c, input string tag);
        apply(el, c, HIT_ENC, 1'b0);
        check_now(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                fails++;
                $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        cur_el = 0; cfg = 0; is_write = 0;
        {op0, op1, crn, crm, op2} = 16'h0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // Idle state: all-zero encoding is no hit (R1).
        check_now("R1");

        // R4: user comms trap, with and without host routing.
        run(2'd0, 10'b0001100001, "R4");
        run(2'd0, 10'b0000100001, "R4");
        // R5: level-2 debug access bit alone.
        run(2'd0, 10'b0100000001, "R5");
        // R6: level-3 check from levels 0 and 1.
        run(2'd0, 10'b1000000010, "R6");
        run(2'd1, 10'b1000000010, "R6");
        // R7: host route ignored at level 1; debug route traps.
        run(2'd1, 10'b0001000001, "R7");
        run(2'd1, 10'b0010000001, "R7");
        // R8: level 2 ignores level-2 bits; level 3 always allowed.
        run(2'd2, 10'b0111100001, "R8");
        run(2'd3, 10'b1111100011, "R8");
        // R10: narrow levels switch off their checks.
        run(2'd0, 10'b0000100100, "R10");
        run(2'd1, 10'b0110001001, "R10");
        run(2'd2, 10'b1000010010, "R10");
        run(2'd0, 10'b0001101001, "R10");

        // R1: every single-bit change of the encoding misses.
        for (int b = 0; b < 16; b++) begin
            apply(2'd0, 10'b1111100011, HIT_ENC ^ (16'h1 << b), 1'b0);
            check_now("R1");
            apply(2'd3, 10'b0, HIT_ENC ^ (16'h1 << b), 1'b1);
            check_now("R1");
        end

        // Exhaustive sweep of level x controls, read then write (R2, R9).
        for (int v = 0; v < 4096; v++) begin
            logic [9:0] rd_out;
            apply(v[1:0], v[11:2], HIT_ENC, 1'b0);
            check_now("R2");
            rd_out = {allow, trap, trap_el, trap_class};
            apply(v[1:0], v[11:2], HIT_ENC, 1'b1);
            check_now("R2");
            checks++;
            if ({allow, trap, trap_el, trap_class} !== rd_out) begin
                fails++;
                $display("FAIL R9 write differs: got %b expected %b",
                         {allow, trap, trap_el, trap_class}, rd_out);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule